// File: doc/BRIEF.md
# Asynchronous UART Receiver with Error Classification

This block receives asynchronous serial characters from an oversampled input line. A sample-rate tick advances an internal bit-phase counter. Three consecutive samples are taken around the middle of every bit, and the majority of the three decides the bit value. The receiver then assembles a character of five to eight data bits, least significant bit first. The character may carry an optional even or odd parity bit and ends with one stop bit. Finished characters go into a two-entry holding FIFO. Each entry carries its own status bits, and a read strobe pops the oldest entry.

Every character is classified for five reception errors: carrier-detect loss, overrun, framing, parity and noise. Carrier loss outranks all the others and discards the character in progress. A framing error suppresses the parity check. A noise error is recorded in the character's status and counted, but it does not close the buffer. Carrier loss, overrun, framing and parity each produce a one-cycle buffer-close strobe with a cause vector. The receive interrupt is that strobe gated by an enable input. Three 16-bit saturating counters track parity, framing and noise errors, and a synchronous clear input resets them.

Top module: `uerx_top`

## Requirements
- R1: Each bit is decided by the majority of three samples taken on sample ticks 3, 4 and 5 of an 8-tick bit. Data arrives LSB first. `data_len` values 0..3 select 5..8 data bits. The character appears in `rd_data` with the unused upper bits zero.
- R2: A start bit whose voted value is 1 is a false start. It produces no FIFO entry and no close strobe.
- R3: If the three samples of any bit of a stored character are not all equal, `rd_stat[0]` is set and the noise counter increments. No close strobe is produced for noise alone.
- R4: `par_mode` selects the parity check: 0 is none, 1 is even, 2 is odd. A mismatch with a valid stop bit has several effects: the character is stored with `rd_stat[1]` set, the parity counter increments, and a close strobe is produced with `close_flags[0]` set.
- R5: A stop bit voted as 0 is a framing error. The character is stored with `rd_stat[2]` set, the framing counter increments, and a close strobe is produced with `close_flags[1]` set. Parity is not evaluated for that character.
- R6: While `cd_gate_en` is 1, a low `cd_ok` during a character discards that character. No error is evaluated and no counter moves. A close strobe is produced with `close_flags` equal to 4'b1000. While `cd_gate_en` is 0, `cd_ok` has no effect.
- R7: A character that completes while both FIFO entries are unread replaces the youngest entry. The replacing entry has `rd_stat[3]` set, and a close strobe is produced with `close_flags[2]` set.
- R8: The FIFO holds 2 characters and is empty after reset. `rd_pop` removes the oldest entry together with its status, and `rd_valid` drops only after a pop.
- R9: The three error counters are 16 bits wide, stop at 16'hFFFF, and read 0 in the cycle after `cnt_clr` is asserted.
- R10: `rx_irq` is high exactly when `close_pulse` is high and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample tick, 8 per bit |
| rxd | input | 1 | Serial receive line, idle high |
| cd_ok | input | 1 | Carrier present when 1 |
| cd_gate_en | input | 1 | Enables carrier-detect gating of reception |
| data_len | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | 0 none, 1 even, 2 odd |
| irq_en | input | 1 | Receive interrupt enable |
| cnt_clr | input | 1 | Synchronous clear of the error counters |
| rd_pop | input | 1 | Pops the oldest FIFO entry |
| rd_valid | output | 1 | FIFO holds at least one character |
| rd_data | output | 8 | Oldest character, zero-extended |
| rd_stat | output | 4 | Oldest entry status {overrun, framing, parity, noise} |
| close_pulse | output | 1 | One-cycle buffer-close strobe |
| close_flags | output | 4 | Close cause {carrier, overrun, framing, parity}, valid with strobe |
| rx_irq | output | 1 | Receive interrupt |
| par_err_cnt | output | 16 | Parity error count |
| frm_err_cnt | output | 16 | Framing error count |
| noise_err_cnt | output | 16 | Noise error count |

## Verification
A sampler that drifts in its bit-phase or bit-index state shows up at the ports as a wrong `rd_data` value or a spurious framing flag. This is visible as soon as the affected character reaches the FIFO head, two cycles after its stop-bit decision. A corrupted FIFO pointer or count shows up at the next pop as a stale or missing character, or as a wrongly placed overrun bit. A misrouted error classification shows up within one character, as a counter that moves by the wrong amount or a close strobe whose cause vector disagrees with the injected fault.

// File: rtl/uerx_pkg.sv
package uerx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } par_mode_e;

    typedef enum logic [0:0] {
        RX_HUNT  = 1'b0,
        RX_FRAME = 1'b1
    } rx_state_e;

    localparam int MAX_DATA = 8;

    typedef struct packed {
        logic [MAX_DATA-1:0] data;
        logic                ov;
        logic                fe;
        logic                pe;
        logic                ne;
    } rx_char_t;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic mixed3(input logic [2:0] s);
        return !((s[0] == s[1]) && (s[1] == s[2]));
    endfunction

endpackage

// File: rtl/uerx_bitsamp.sv
module uerx_bitsamp
    import uerx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     os_tick,
    input  logic     rxd,
    input  logic     cd_ok,
    input  logic     cd_gate_en,
    input  logic [1:0] data_len,
    input  logic [1:0] par_mode,
    output logic     done,
    output rx_char_t done_char,
    output logic     cd_abort
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam logic [CW-1:0] S_LO  = CW'(MID - 1);
    localparam logic [CW-1:0] S_HI  = CW'(MID + 1);
    localparam logic [CW-1:0] S_END = CW'(OVS - 1);

    rx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [3:0]        idx;
    logic [1:0]        smp;
    logic [MAX_DATA-1:0] dat;
    logic              ne_acc;
    logic              par_rx;
    logic [3:0]        n_data;
    par_mode_e         pm;

    logic       in_win, decide, vote, noisy, par_on, carrier_lost;
    logic [3:0] stop_idx, dix;
    logic       par_bad;

    always_comb begin
        in_win       = (cnt >= S_LO) && (cnt <= S_HI);
        decide       = (cnt == S_HI);
        vote         = maj3({smp, rxd});
        noisy        = mixed3({smp, rxd});
        par_on       = (pm == PAR_EVEN) || (pm == PAR_ODD);
        stop_idx     = 4'd1 + n_data + {3'b000, par_on};
        dix          = idx - 4'd1;
        par_bad      = ((par_rx ^ (^dat)) != (pm == PAR_ODD));
        carrier_lost = cd_gate_en && !cd_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_HUNT;
            cnt       <= '0;
            idx       <= '0;
            smp       <= '0;
            dat       <= '0;
            ne_acc    <= 1'b0;
            par_rx    <= 1'b0;
            n_data    <= 4'd8;
            pm        <= PAR_NONE;
            done      <= 1'b0;
            done_char <= '0;
            cd_abort  <= 1'b0;
        end else begin
            done     <= 1'b0;
            cd_abort <= 1'b0;
            case (st)
                RX_HUNT: begin
                    if (os_tick && !rxd && !carrier_lost) begin
                        st     <= RX_FRAME;
                        cnt    <= CW'(1);
                        idx    <= '0;
                        dat    <= '0;
                        ne_acc <= 1'b0;
                        par_rx <= 1'b0;
                        n_data <= 4'd5 + {2'b00, data_len};
                        pm     <= par_mode_e'(par_mode);
                    end
                end
                RX_FRAME: begin
                    if (carrier_lost) begin
                        st       <= RX_HUNT;
                        cd_abort <= 1'b1;
                    end else if (os_tick) begin
                        if (in_win) smp <= {smp[0], rxd};
                        if (cnt == S_END) begin
                            cnt <= '0;
                            idx <= idx + 4'd1;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                        if (decide) begin
                            if (noisy) ne_acc <= 1'b1;
                            if (idx == 4'd0) begin
                                if (vote) st <= RX_HUNT;
                            end else if (idx <= n_data) begin
                                dat[dix[2:0]] <= vote;
                            end else if (idx == stop_idx) begin
                                st                <= RX_HUNT;
                                done              <= 1'b1;
                                done_char.data    <= dat;
                                done_char.ov      <= 1'b0;
                                done_char.fe      <= !vote;
                                done_char.pe      <= par_on && vote && par_bad;
                                done_char.ne      <= ne_acc || noisy;
                            end else begin
                                par_rx <= vote;
                            end
                        end
                    end
                end
                default: st <= RX_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/uerx_fifo.sv
module uerx_fifo
    import uerx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_char_t din,
    input  logic     pop,
    output logic     valid,
    output logic     full,
    output rx_char_t dout
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]   LAST  = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULLC = CNTW'(DEPTH);

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   rp, wp, wp_prev;
    logic [CNTW-1:0] cnt;
    logic            do_pop, do_ovw, do_push;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        valid   = (cnt != '0);
        full    = (cnt == FULLC);
        dout    = mem[rp];
        wp_prev = (wp == '0) ? LAST : wp - AW'(1);
        do_pop  = pop && valid;
        do_ovw  = push && full && !do_pop;
        do_push = push && !do_ovw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= ptr_next(wp);
            end
            if (do_ovw) mem[wp_prev] <= din;
            if (do_pop) rp <= ptr_next(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CNTW'(1);
                2'b01:   cnt <= cnt - CNTW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/uerx_satcnt.sv
module uerx_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc && (q != '1)) begin
            q <= q + W'(1);
        end
    end
endmodule

// File: rtl/uerx_top.sv
module uerx_top
    import uerx_pkg::*;
#(
    parameter int OVS   = 8,
    parameter int DEPTH = 2,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             os_tick,
    input  logic             rxd,
    input  logic             cd_ok,
    input  logic             cd_gate_en,
    input  logic [1:0]       data_len,
    input  logic [1:0]       par_mode,
    input  logic             irq_en,
    input  logic             cnt_clr,
    input  logic             rd_pop,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic [3:0]       rd_stat,
    output logic             close_pulse,
    output logic [3:0]       close_flags,
    output logic             rx_irq,
    output logic [CNT_W-1:0] par_err_cnt,
    output logic [CNT_W-1:0] frm_err_cnt,
    output logic [CNT_W-1:0] noise_err_cnt
);
    localparam int NCNT = 3;

    logic     done, cd_abort, fifo_full, fifo_valid, pop_ok, ovr;
    rx_char_t done_char, push_char, head;
    logic [NCNT-1:0]  cnt_inc;
    logic [CNT_W-1:0] cnt_q [NCNT];
    logic             close_q;
    logic [3:0]       flags_q;

    uerx_bitsamp #(.OVS(OVS)) u_samp (
        .clk       (clk),
        .rst       (rst),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .cd_ok     (cd_ok),
        .cd_gate_en(cd_gate_en),
        .data_len  (data_len),
        .par_mode  (par_mode),
        .done      (done),
        .done_char (done_char),
        .cd_abort  (cd_abort)
    );

    always_comb begin
        pop_ok       = rd_pop && fifo_valid;
        ovr          = done && fifo_full && !pop_ok;
        push_char    = done_char;
        push_char.ov = ovr;
    end

    uerx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (done),
        .din  (push_char),
        .pop  (rd_pop),
        .valid(fifo_valid),
        .full (fifo_full),
        .dout (head)
    );

    assign cnt_inc = {done && done_char.ne, done && done_char.fe, done && done_char.pe};

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        uerx_satcnt #(.W(CNT_W)) u_cnt (
            .clk(clk),
            .rst(rst),
            .clr(cnt_clr),
            .inc(cnt_inc[g]),
            .q  (cnt_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            close_q <= 1'b0;
            flags_q <= '0;
        end else if (cd_abort) begin
            close_q <= 1'b1;
            flags_q <= 4'b1000;
        end else if (done && (done_char.pe || done_char.fe || ovr)) begin
            close_q <= 1'b1;
            flags_q <= {1'b0, ovr, done_char.fe, done_char.pe};
        end else begin
            close_q <= 1'b0;
            flags_q <= '0;
        end
    end

    assign rd_valid      = fifo_valid;
    assign rd_data       = head.data;
    assign rd_stat       = {head.ov, head.fe, head.pe, head.ne};
    assign close_pulse   = close_q;
    assign close_flags   = flags_q;
    assign rx_irq        = close_q && irq_en;
    assign par_err_cnt   = cnt_q[0];
    assign frm_err_cnt   = cnt_q[1];
    assign noise_err_cnt = cnt_q[2];

endmodule

// File: rtl/uerx_chk.sv
module uerx_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_clr,
    input logic             rd_pop,
    input logic             rd_valid,
    input logic [3:0]       rd_stat,
    input logic             close_pulse,
    input logic [3:0]       close_flags,
    input logic [CNT_W-1:0] par_err_cnt,
    input logic [CNT_W-1:0] frm_err_cnt,
    input logic [CNT_W-1:0] noise_err_cnt
);
    AST_CD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        close_flags[3] |-> (close_flags[2:0] == 3'b000)); // R6

    AST_FE_NO_PE: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_stat[2]) |-> !rd_stat[1]); // R5

    AST_CLOSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        close_pulse |-> (close_flags != 4'b0000)); // R4

    AST_PAR_SAT: assert property (@(posedge clk) disable iff (rst)
        (par_err_cnt == '1 && !cnt_clr) |=> (par_err_cnt == '1)); // R9

    AST_FRM_SAT: assert property (@(posedge clk) disable iff (rst)
        (frm_err_cnt == '1 && !cnt_clr) |=> (frm_err_cnt == '1)); // R9

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (par_err_cnt == '0 && frm_err_cnt == '0 && noise_err_cnt == '0)); // R9

    AST_NOISE_STEP: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr |=> (noise_err_cnt == $past(noise_err_cnt) ||
                      noise_err_cnt == $past(noise_err_cnt) + CNT_W'(1))); // R3

    AST_VALID_DROP_ON_POP: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> $past(rd_pop)); // R8
endmodule

bind uerx_top uerx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cnt_clr      (cnt_clr),
    .rd_pop       (rd_pop),
    .rd_valid     (rd_valid),
    .rd_stat      (rd_stat),
    .close_pulse  (close_pulse),
    .close_flags  (close_flags),
    .par_err_cnt  (par_err_cnt),
    .frm_err_cnt  (frm_err_cnt),
    .noise_err_cnt(noise_err_cnt)
);

// File: tb/tb_uerx_top.sv
module tb_uerx_top;
    localparam int CLK_PERIOD = 10;
    localparam int OVS  = 8;
    localparam int TDIV = 2;
    localparam int MID  = OVS / 2;

    logic clk, rst, os_tick, rxd, cd_ok, cd_gate_en, irq_en, cnt_clr, rd_pop;
    logic [1:0] data_len, par_mode;
    logic rd_valid, close_pulse, rx_irq;
    logic [7:0] rd_data;
    logic [3:0] rd_stat, close_flags;
    logic [15:0] par_err_cnt, frm_err_cnt, noise_err_cnt;

    uerx_top #(.OVS(OVS), .DEPTH(2), .CNT_W(16)) dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .cd_ok(cd_ok),
        .cd_gate_en(cd_gate_en), .data_len(data_len), .par_mode(par_mode),
        .irq_en(irq_en), .cnt_clr(cnt_clr), .rd_pop(rd_pop),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_stat(rd_stat),
        .close_pulse(close_pulse), .close_flags(close_flags), .rx_irq(rx_irq),
        .par_err_cnt(par_err_cnt), .frm_err_cnt(frm_err_cnt),
        .noise_err_cnt(noise_err_cnt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    int n_close = 0, n_irq = 0, n_stray = 0;
    logic [3:0] last_flags = 4'h0;
    bit finished = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (close_pulse) begin
                n_close++;
                last_flags = close_flags;
                if (rx_irq) n_irq++;
            end else if (rx_irq) begin
                n_stray++;
            end
        end
    end

    // bench reference state
    logic [7:0] m_data [2];
    logic [3:0] m_stat [2];
    int m_cnt = 0;
    int e_par = 0, e_frm = 0, e_noise = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic par_bit(input logic [7:0] d, input int len, input int pm);
        logic p = 1'b0;
        for (int i = 0; i < len; i++) p = p ^ d[i];
        return (pm == 2) ? ~p : p;
    endfunction

    task automatic tick_bit(input logic b, input bit glitch);
        for (int t = 0; t < OVS; t++) begin
            for (int d = 0; d < TDIV; d++) begin
                @(negedge clk);
                os_tick = (d == 0);
                rxd = (glitch && t == MID) ? ~b : b;
            end
        end
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            for (int d = 0; d < TDIV; d++) begin
                @(negedge clk);
                os_tick = (d == 0);
                rxd = 1'b1;
            end
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input int len, input int pm,
                              input bit flip_par, input bit bad_stop,
                              input int noise_at, input int cd_at);
        logic bits [12];
        int nb = 0;
        data_len = 2'(len - 5);
        par_mode = 2'(pm);
        bits[nb++] = 1'b0;
        for (int i = 0; i < len; i++) bits[nb++] = d[i];
        if (pm != 0) bits[nb++] = par_bit(d, len, pm) ^ flip_par;
        bits[nb++] = !bad_stop;
        for (int k = 0; k < nb; k++) begin
            if (k == cd_at) cd_ok = 1'b0;
            tick_bit(bits[k], k == noise_at);
        end
        idle_ticks(2 * OVS);
        cd_ok = 1'b1;
    endtask

    // full frame with expectation bookkeeping and checks
    task automatic do_frame(input string req, input logic [7:0] d, input int len,
                            input int pm, input bit flip_par, input bit bad_stop,
                            input int noise_at, input int cd_at);
        int s_close = n_close, s_irq = n_irq;
        bit cd_hit = cd_gate_en && (cd_at >= 0);
        bit e_fe = bad_stop;
        bit e_pe = (pm != 0) && flip_par && !bad_stop;
        bit e_ne = (noise_at >= 0);
        bit e_ov = 1'b0;
        bit e_close;
        logic [3:0] e_flags;
        logic [7:0] dm = d & 8'(( 1 << len) - 1);
        send_frame(d, len, pm, flip_par, bad_stop, noise_at, cd_at);
        if (cd_hit) begin
            e_close = 1'b1;
            e_flags = 4'b1000;
        end else begin
            if (m_cnt == 2) begin
                e_ov = 1'b1;
                m_data[1] = dm;
                m_stat[1] = {e_ov, e_fe, e_pe, e_ne};
            end else begin
                m_data[m_cnt] = dm;
                m_stat[m_cnt] = {e_ov, e_fe, e_pe, e_ne};
                m_cnt++;
            end
            if (e_pe) e_par++;
            if (e_fe) e_frm++;
            if (e_ne) e_noise++;
            e_close = e_pe || e_fe || e_ov;
            e_flags = {1'b0, e_ov, e_fe, e_pe};
        end
        chk(n_close == s_close + int'(e_close), req, "close strobe count", n_close - s_close, int'(e_close));
        if (e_close) chk(last_flags == e_flags, req, "close cause", last_flags, e_flags);
        chk(n_irq == s_irq + int'(e_close && irq_en), "R10", "irq count", n_irq - s_irq, int'(e_close && irq_en));
        chk(rd_valid == (m_cnt != 0), req, "rd_valid", rd_valid, m_cnt != 0);
        chk(par_err_cnt == 16'(e_par), req, "parity counter", par_err_cnt, e_par);
        chk(frm_err_cnt == 16'(e_frm), req, "framing counter", frm_err_cnt, e_frm);
        chk(noise_err_cnt == 16'(e_noise), req, "noise counter", noise_err_cnt, e_noise);
    endtask

    task automatic pop_check(input string req);
        @(negedge clk);
        chk(rd_valid == 1'b1, "R8", "rd_valid before pop", rd_valid, 1);
        chk(rd_data == m_data[0], req, "rd_data", rd_data, m_data[0]);
        chk(rd_stat == m_stat[0], req, "rd_stat", rd_stat, m_stat[0]);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        m_data[0] = m_data[1];
        m_stat[0] = m_stat[1];
        m_cnt--;
        chk(rd_valid == (m_cnt != 0), "R8", "rd_valid after pop", rd_valid, m_cnt != 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; os_tick = 1'b0; rxd = 1'b1; cd_ok = 1'b1; cd_gate_en = 1'b0;
        data_len = 2'd3; par_mode = 2'd0; irq_en = 1'b1; cnt_clr = 1'b0; rd_pop = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R8", "reset rd_valid", rd_valid, 0);
        chk(close_pulse == 1'b0 && rx_irq == 1'b0, "R10", "reset strobe", close_pulse, 0);
        chk(par_err_cnt == 0 && frm_err_cnt == 0 && noise_err_cnt == 0, "R9", "reset counters", par_err_cnt, 0);
        idle_ticks(OVS);

        // R1: clean 8-bit, no parity
        do_frame("R1", 8'hA5, 8, 0, 0, 0, -1, -1);
        pop_check("R1");
        // R1: 5-bit with even parity, upper bits dropped
        do_frame("R1", 8'hF3, 5, 1, 0, 0, -1, -1);
        pop_check("R1");

        // R2: false start - low for two ticks only
        begin
            int s_close = n_close;
            tick_bit(1'b1, 1'b0);
            for (int t = 0; t < 2; t++) begin
                for (int d = 0; d < TDIV; d++) begin
                    @(negedge clk); os_tick = (d == 0); rxd = 1'b0;
                end
            end
            idle_ticks(3 * OVS);
            chk(rd_valid == 1'b0, "R2", "false start stored", rd_valid, 0);
            chk(n_close == s_close, "R2", "false start close", n_close - s_close, 0);
        end

        // R3: glitch on a data bit
        do_frame("R3", 8'h3C, 8, 1, 0, 0, 3, -1);
        pop_check("R3");
        // R3: glitch on the start bit
        do_frame("R3", 8'h11, 6, 0, 0, 0, 0, -1);
        pop_check("R3");

        // R4: odd parity mismatch with interrupt masked
        irq_en = 1'b0;
        do_frame("R4", 8'h5A, 7, 2, 1, 0, -1, -1);
        pop_check("R4");
        irq_en = 1'b1;
        do_frame("R4", 8'hC1, 8, 1, 1, 0, -1, -1);
        pop_check("R4");

        // R5: bad stop together with bad parity: parity suppressed
        do_frame("R5", 8'h77, 8, 1, 1, 1, -1, -1);
        pop_check("R5");

        // R6: carrier loss with gating enabled, then with gating off
        cd_gate_en = 1'b1;
        do_frame("R6", 8'h96, 8, 1, 1, 1, -1, 4);
        chk(rd_valid == 1'b0, "R6", "aborted char stored", rd_valid, 0);
        cd_gate_en = 1'b0;
        do_frame("R6", 8'h96, 8, 0, 0, 0, -1, 4);
        pop_check("R6");

        // R7: three characters with no reads
        do_frame("R7", 8'h01, 8, 0, 0, 0, -1, -1);
        do_frame("R7", 8'h02, 8, 0, 0, 0, -1, -1);
        do_frame("R7", 8'h03, 8, 0, 0, 0, -1, -1);
        pop_check("R7");
        pop_check("R7");

        // R9: synchronous clear
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        chk(par_err_cnt == 0 && frm_err_cnt == 0 && noise_err_cnt == 0, "R9", "counters after clear",
            par_err_cnt + frm_err_cnt + noise_err_cnt, 0);
        e_par = 0; e_frm = 0; e_noise = 0;

        // random traffic
        for (int n = 0; n < 60; n++) begin
            int len = 5 + int'($urandom_range(0, 3));
            int pm = int'($urandom_range(0, 2));
            int nbits = 2 + len + ((pm != 0) ? 1 : 0);
            bit fp = ($urandom_range(0, 3) == 0);
            bit bs = ($urandom_range(0, 5) == 0);
            int na = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, nbits - 1)) : -1;
            irq_en = 1'($urandom_range(0, 1));
            do_frame("R1", 8'($urandom), len, pm, fp, bs, na, -1);
            if (m_cnt != 0 && $urandom_range(0, 2) != 0) pop_check("R8");
        end
        while (m_cnt != 0) pop_check("R8");
        chk(n_stray == 0, "R10", "irq without close", n_stray, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule